// File: doc/BRIEF.md
# Cascadable Programmable Interrupt Controller

This block gathers eight interrupt request lines, orders them by fixed priority with full nesting, and presents one interrupt output to a processor. Software talks to it through two byte-wide addresses chosen by a single address bit. The control address (bit 0) and the auxiliary address (bit 1) share a stateful setup sequence: a control write with data bit 4 set restarts setup, and the next auxiliary writes supply the vector base, the cascade wiring byte and, if asked for, a mode byte. After setup the auxiliary address carries the mask, and the control address carries end-of-interrupt and read-select commands.

Each input is edge or level sensed. An external control byte picks level sensing per input, and setup can force level sensing for every input at once. Inputs 0 to 2 always stay edge sensed. When the processor pulses the acknowledge strobe, the winning request moves into service and an 8-bit vector appears for one cycle. If nothing valid is pending, the spurious vector for input 7 is returned. The cascade byte is kept and shown on a port for the wiring of a multi-chip system.

Top module: `prog_irq_ctrl`

## Requirements
- R1: After reset the interrupt output is low, an auxiliary read returns 0xFF (all inputs masked), a control read returns 0x00 and no setup has completed.
- R2: A control write with data bit 4 set starts setup. It clears the mask and in-service bits, sets control reads to the request register and holds the interrupt output low. The next auxiliary writes are the base byte, then the cascade byte, then a mode byte only when bit 0 of that first write was 1.
- R3: Bits 7:3 of the base byte are kept. The delivered vector is {base[7:3], n}, where n is the 3-bit number of the input.
- R4: The cascade byte is captured as written and driven on `casc_cfg`.
- R5: Once setup is complete, auxiliary writes load the mask (1 disables an input) and auxiliary reads return it. A masked pending request does not raise the interrupt output.
- R6: Once setup is complete, a control write of 0x20 clears the lowest-numbered bit set in the in-service register.
- R7: A control write with bit 4 = 0, bit 3 = 1 and low bits 11 makes control reads return the in-service register. Low bits 10 make them return the request register.
- R8: Input 0 has the highest priority. The interrupt output is high only when setup is complete and an unmasked pending request has a lower index than every in-service bit.
- R9: An edge-sensed input sets its request bit on a rising edge. The bit is cleared when that input is acknowledged, and an input held high does not request again.
- R10: An input 3 to 7 whose `trig_level` bit is 1 is level sensed, and its request bit follows the input. A `trig_level` bit for inputs 0 to 2 has no effect.
- R11: An acknowledge while the interrupt output is high moves the winner into service and drives its vector, with `vec_valid` high during the one cycle after the strobe.
- R12: An acknowledge while the interrupt output is low returns {base[7:3], 3'd7} and leaves the in-service register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_addr | input | 1 | 0 = control address, 1 = auxiliary address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the byte selected by `bus_addr` |
| irq_in | input | 8 | Interrupt request inputs |
| trig_level | input | 8 | Level-sense select for each input, 1 = level |
| int_out | output | 1 | Interrupt request to the processor |
| ack | input | 1 | Acknowledge strobe |
| vec_valid | output | 1 | Vector is valid this cycle |
| vec_out | output | 8 | Interrupt vector |
| casc_cfg | output | 8 | Captured cascade wiring byte |

## Verification
The bench nests requests so that a lower-priority request arrives while a higher one is in service. A design that ignored nesting would raise the output too early, and one that cleared the wrong in-service bit on end-of-interrupt would deliver the wrong vector next. It holds an edge input high through acknowledge to catch a design that requests again, and it holds a level input high past end-of-interrupt to catch one that loses the request. It sets the level select on input 0, which must stay edge sensed. It acknowledges with nothing pending to catch a missing spurious code. Finally it repeats setup without the mode byte, so a design that always waits for that byte would take the mask write as setup data.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int NIN  = 8;
    localparam int IDXW = $clog2(NIN);
    localparam int VBW  = 8 - IDXW;

    localparam logic [7:0]     OP_EOI    = 8'h20;
    localparam logic [NIN-1:0] EDGE_ONLY = 8'h07;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_BASE,
        ST_CASC,
        ST_MODE,
        ST_RUN
    } init_st_t;

    typedef enum logic {
        RD_REQ,
        RD_SVC
    } rdsel_t;

    typedef struct packed {
        logic            hit;
        logic [IDXW-1:0] idx;
    } pick_t;

    function automatic pick_t pick_lowest(input logic [NIN-1:0] v);
        pick_t r;
        r = '0;
        for (int i = NIN - 1; i >= 0; i--) begin
            if (v[i]) begin
                r.hit = 1'b1;
                r.idx = IDXW'(i);
            end
        end
        return r;
    endfunction

    function automatic logic [NIN-1:0] to_onehot(input logic [IDXW-1:0] idx);
        logic [NIN-1:0] r;
        r = '0;
        r[idx] = 1'b1;
        return r;
    endfunction
endpackage

// File: rtl/pic_cmd_decode.sv
module pic_cmd_decode
    import pic_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr,
    input  logic                addr,
    input  logic [7:0]          wdata,
    output logic                ready,
    output logic                icw1_hit,
    output logic                eoi_hit,
    output logic                glob_level,
    output logic [VBW-1:0]      base,
    output logic [7:0]          casc,
    output logic [NIN-1:0]      imr,
    output rdsel_t              rsel
);
    init_st_t st_q;
    logic     need_mode_q;

    assign icw1_hit = wr && !addr && wdata[4];
    assign ready    = (st_q == ST_RUN);
    assign eoi_hit  = wr && !addr && ready && (wdata == OP_EOI);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= ST_OFF;
            need_mode_q <= 1'b0;
            glob_level  <= 1'b0;
            base        <= '0;
            casc        <= '0;
            imr         <= '1;
            rsel        <= RD_REQ;
        end else if (icw1_hit) begin
            st_q        <= ST_BASE;
            need_mode_q <= wdata[0];
            glob_level  <= wdata[3];
            imr         <= '0;
            rsel        <= RD_REQ;
        end else if (wr && addr) begin
            case (st_q)
                ST_BASE: begin
                    base <= wdata[7:IDXW];
                    st_q <= ST_CASC;
                end
                ST_CASC: begin
                    casc <= wdata;
                    st_q <= need_mode_q ? ST_MODE : ST_RUN;
                end
                ST_MODE: st_q <= ST_RUN;
                ST_RUN:  imr  <= wdata[NIN-1:0];
                default: ;
            endcase
        end else if (wr && ready && wdata[3] && wdata[1]) begin
            rsel <= wdata[0] ? RD_SVC : RD_REQ;
        end
    end
endmodule

// File: rtl/pic_req_latch.sv
module pic_req_latch
    import pic_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [NIN-1:0] irq_in,
    input  logic [NIN-1:0] level_mask,
    input  logic [NIN-1:0] clr,
    output logic [NIN-1:0] irr
);
    logic [NIN-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= irq_in;
    end

    for (genvar g = 0; g < NIN; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                irr[g] <= 1'b0;
            else if (level_mask[g])
                irr[g] <= irq_in[g];
            else
                irr[g] <= (irr[g] && !clr[g]) || (irq_in[g] && !prev_q[g]);
        end
    end
endmodule

// File: rtl/pic_prio_resolve.sv
module pic_prio_resolve
    import pic_pkg::*;
(
    input  logic            ready,
    input  logic [NIN-1:0]  irr,
    input  logic [NIN-1:0]  imr,
    input  logic [NIN-1:0]  isr,
    output logic            int_req,
    output logic [IDXW-1:0] win_idx,
    output logic [NIN-1:0]  svc_top
);
    pick_t pend_p;
    pick_t svc_p;

    always_comb begin
        pend_p  = pick_lowest(irr & ~imr);
        svc_p   = pick_lowest(isr);
        win_idx = pend_p.idx;
        svc_top = svc_p.hit ? to_onehot(svc_p.idx) : '0;
        int_req = ready && pend_p.hit && (!svc_p.hit || (pend_p.idx < svc_p.idx));
    end
endmodule

// File: rtl/prog_irq_ctrl.sv
module prog_irq_ctrl
    import pic_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_wr,
    input  logic       bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic [7:0] irq_in,
    input  logic [7:0] trig_level,
    output logic       int_out,
    input  logic       ack,
    output logic       vec_valid,
    output logic [7:0] vec_out,
    output logic [7:0] casc_cfg
);
    logic            run_q;
    logic            icw1_hit, eoi_hit, glob_level;
    logic [VBW-1:0]  base;
    logic [NIN-1:0]  imr_w, irr_w, isr_q, svc_top, level_mask, take;
    logic [IDXW-1:0] win_idx;
    logic            int_req;
    rdsel_t          rsel;

    pic_cmd_decode u_dec (
        .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .ready(run_q), .icw1_hit(icw1_hit), .eoi_hit(eoi_hit),
        .glob_level(glob_level), .base(base), .casc(casc_cfg),
        .imr(imr_w), .rsel(rsel)
    );

    assign level_mask = (glob_level ? '1 : trig_level) & ~EDGE_ONLY;
    assign take       = (ack && int_req) ? to_onehot(win_idx) : '0;

    pic_req_latch u_req (
        .clk(clk), .rst(rst), .irq_in(irq_in), .level_mask(level_mask),
        .clr(take), .irr(irr_w)
    );

    pic_prio_resolve u_prio (
        .ready(run_q), .irr(irr_w), .imr(imr_w), .isr(isr_q),
        .int_req(int_req), .win_idx(win_idx), .svc_top(svc_top)
    );

    assign int_out = int_req;

    always_ff @(posedge clk) begin
        if (rst || icw1_hit)
            isr_q <= '0;
        else
            isr_q <= (isr_q & ~(eoi_hit ? svc_top : '0)) | take;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_valid <= 1'b0;
            vec_out   <= '0;
        end else begin
            vec_valid <= ack;
            if (ack)
                vec_out <= {base, int_req ? win_idx : IDXW'(NIN - 1)};
        end
    end

    always_comb begin
        if (bus_addr)
            bus_rdata = imr_w;
        else
            bus_rdata = (rsel == RD_SVC) ? isr_q : irr_w;
    end
endmodule

// File: rtl/pic_checks.sv
module pic_checks (
    input logic       clk,
    input logic       rst,
    input logic       ack,
    input logic       bus_wr,
    input logic       bus_addr,
    input logic [7:0] bus_wdata,
    input logic       int_out,
    input logic       vec_valid,
    input logic [7:0] vec_out,
    input logic       ready,
    input logic [7:0] isr,
    input logic [7:0] irr,
    input logic [7:0] imr
);
    p_vec_after_ack_r11: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> $past(ack));

    p_take_grows_isr_r11: assert property (@(posedge clk) disable iff (rst)
        (ack && int_out && !bus_wr) |=> ($countones(isr) == $countones($past(isr)) + 1));

    p_spurious_code_r12: assert property (@(posedge clk) disable iff (rst)
        (ack && !int_out && !bus_wr) |=> (vec_valid && vec_out[2:0] == 3'd7 && isr == $past(isr)));

    p_int_gated_r8: assert property (@(posedge clk) disable iff (rst)
        int_out |-> (ready && ((irr & ~imr) != 8'h00)));

    p_eoi_shrinks_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !bus_addr && bus_wdata == 8'h20 && ready && isr != 8'h00 && !ack)
        |=> ($countones(isr) + 1 == $countones($past(isr))));

    p_all_masked_r5: assert property (@(posedge clk) disable iff (rst)
        (imr == 8'hFF) |-> !int_out);
endmodule

bind prog_irq_ctrl pic_checks u_pic_checks (
    .clk(clk), .rst(rst), .ack(ack), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .int_out(int_out), .vec_valid(vec_valid),
    .vec_out(vec_out), .ready(run_q), .isr(isr_q), .irr(irr_w), .imr(imr_w)
);

// File: tb/test_prog_irq_ctrl.sv
`timescale 1ns/1ps
module test_prog_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] irq_in = '0;
    logic [7:0] trig_level = '0;
    logic       int_out;
    logic       ack = 1'b0;
    logic       vec_valid;
    logic [7:0] vec_out;
    logic [7:0] casc_cfg;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    prog_irq_ctrl i_prog_irq_ctrl (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
        .trig_level(trig_level), .int_out(int_out), .ack(ack),
        .vec_valid(vec_valid), .vec_out(vec_out), .casc_cfg(casc_cfg)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic a, input logic [7:0] exp);
        bus_addr = a;
        #0.5;
        check(req, bus_rdata, exp);
    endtask

    task automatic set_irq(input logic [7:0] v);
        @(negedge clk);
        irq_in = v;
        @(negedge clk);
    endtask

    task automatic do_ack(input string req, input logic [7:0] exp);
        @(negedge clk);
        exp_q.push_back(exp);
        tag_q.push_back(req);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
        @(negedge clk);
    endtask

    // monitor: pops expected vectors as the design delivers them
    always @(negedge clk) begin
        if (!rst && vec_valid) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R11: actual %02h expected none", vec_out);
            end else begin
                string t;
                logic [7:0] e;
                t = tag_q.pop_front();
                e = exp_q.pop_front();
                check(t, vec_out, e);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 int", {7'd0, int_out}, 8'h00);
        rd_check("R1 imr", 1'b1, 8'hFF);
        rd_check("R1 ctrl", 1'b0, 8'h00);

        // R2 setup with mode byte
        wr(1'b0, 8'h11);
        rd_check("R2 imr cleared", 1'b1, 8'h00);
        wr(1'b1, 8'h40);
        wr(1'b1, 8'h04);
        check("R4 casc", casc_cfg, 8'h04);
        wr(1'b1, 8'h01);
        wr(1'b1, 8'h00);
        rd_check("R5 imr", 1'b1, 8'h00);

        // R9 edge request, R11 acknowledge
        set_irq(8'h08);
        check("R8 int raised", {7'd0, int_out}, 8'h01);
        rd_check("R9 irr", 1'b0, 8'h08);
        do_ack("R11 vec irq3", 8'h43);
        wr(1'b0, 8'h0B);
        rd_check("R7 isr", 1'b0, 8'h08);
        wr(1'b0, 8'h0A);
        rd_check("R9 irr cleared held high", 1'b0, 8'h00);
        check("R9 no re-request", {7'd0, int_out}, 8'h00);

        // R8 nesting
        set_irq(8'h28);
        check("R8 lower blocked", {7'd0, int_out}, 8'h00);
        set_irq(8'h2A);
        check("R8 higher preempts", {7'd0, int_out}, 8'h01);
        do_ack("R3 vec irq1", 8'h41);
        wr(1'b0, 8'h0B);
        rd_check("R11 isr nested", 1'b0, 8'h0A);
        wr(1'b0, 8'h20);
        rd_check("R6 eoi clears top", 1'b0, 8'h08);
        check("R8 still blocked", {7'd0, int_out}, 8'h00);
        wr(1'b0, 8'h20);
        check("R8 unblocked", {7'd0, int_out}, 8'h01);
        do_ack("R8 vec irq5", 8'h45);
        wr(1'b0, 8'h20);

        // R5 mask
        set_irq(8'h00);
        wr(1'b1, 8'h10);
        set_irq(8'h10);
        check("R5 masked", {7'd0, int_out}, 8'h00);
        wr(1'b0, 8'h0A);
        rd_check("R7 irr sel", 1'b0, 8'h10);
        wr(1'b1, 8'h00);
        check("R5 unmasked", {7'd0, int_out}, 8'h01);
        do_ack("R5 vec irq4", 8'h44);
        wr(1'b0, 8'h20);

        // R12 spurious
        check("R12 idle", {7'd0, int_out}, 8'h00);
        do_ack("R12 spurious", 8'h47);
        wr(1'b0, 8'h0B);
        rd_check("R12 isr unchanged", 1'b0, 8'h00);

        // R10 level sensing
        trig_level = 8'h41;
        set_irq(8'h40);
        check("R10 level raise", {7'd0, int_out}, 8'h01);
        do_ack("R10 vec irq6", 8'h46);
        wr(1'b0, 8'h20);
        check("R10 level persists", {7'd0, int_out}, 8'h01);
        set_irq(8'h00);
        @(negedge clk);
        check("R10 level follows low", {7'd0, int_out}, 8'h00);
        set_irq(8'h01);
        do_ack("R10 forced edge irq0", 8'h40);
        wr(1'b0, 8'h20);
        check("R10 input0 stays edge", {7'd0, int_out}, 8'h00);

        // R2 re-setup without mode byte
        set_irq(8'h05);
        wr(1'b0, 8'h10);
        rd_check("R2 read sel to irr", 1'b0, 8'h04);
        check("R2 int held low", {7'd0, int_out}, 8'h00);
        wr(1'b1, 8'h85);
        wr(1'b1, 8'h02);
        check("R4 casc slave", casc_cfg, 8'h02);
        wr(1'b1, 8'hFB);
        rd_check("R2 no mode byte", 1'b1, 8'hFB);
        do_ack("R3 new base", 8'h82);

        repeat (3) @(negedge clk);
        check("R11 queue drained", 8'(exp_q.size()), 8'h00);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule